// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block models how an in-order front end packs instructions into a fixed-size dispatch group. Each cycle a scheduler presents one candidate instruction. The candidate arrives as a unit class and a set of pre-decoded flags. The block answers at once with a two-bit verdict: the candidate may go now, it must wait for a fresh group, or a filler no-op must be placed ahead of it.

The block keeps two pieces of state:
- a slot counter for the open group;
- a flag recording that the count register was written inside that group.

A commit strobe charges the presented candidate to the group. A no-op strobe charges one empty slot. Branch and single-slot instructions close the group early. Cracked instructions take two slots. When the count reaches the group size, the group ends and the per-group state clears.

Address comparison for loads against earlier stores is done outside the block, and its result enters as a single flag.

Top module: `dgroup_slot_guard`

## Requirements
- R1: After synchronous active-high reset the group is empty, so a first-only candidate and a condition-register candidate both receive verdict 00 (go).
- R2: A non-pseudo candidate flagged first-only or single receives verdict 01 (wait) whenever at least one slot of the open group is used.
- R3: A cracked candidate receives verdict 01 when more than two slots are used. Committing a cracked candidate charges two slots.
- R4: Unit codes 1 (fixed-point), 2 (load/store), 3 (float), 4 (vector ALU) and 5 (vector permute) receive verdict 01 when exactly four slots are used. Unit code 7 (branch) is never refused by slot position.
- R5: Unit code 6 (condition-register) receives verdict 01 once two or more slots are used.
- R6: Committing a branch (unit 7) or a single candidate closes the group, so the next group starts with zero slots used.
- R7: When the slot count reaches five the group ends. The count returns to zero and the count-register-written flag clears.
- R8: After a committed count-register write in the open group, a branch-via-count-register candidate receives verdict 10 (insert no-op), unless a slot rule already gives 01.
- R9: A no-op strobe charges exactly one slot.
- R10: A pseudo candidate (unit code 0) always receives verdict 00, and committing it changes no state.
- R11: A non-pseudo candidate with the load-overlap flag set receives verdict 10 when no slot rule applies.
- R12: Commit and no-op strobes in the same cycle raise the clash output and leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_unit | input | 3 | Candidate unit class code |
| cand_first | input | 1 | Candidate may only take the first slot |
| cand_single | input | 1 | Candidate occupies a whole group |
| cand_cracked | input | 1 | Candidate splits into two operations |
| cand_sets_cnt | input | 1 | Candidate writes the count register |
| cand_br_cnt | input | 1 | Candidate branches through the count register |
| cand_ld_overlap | input | 1 | Candidate load overlaps an earlier store in the group |
| commit | input | 1 | Charge the candidate to the group |
| noop_adv | input | 1 | Charge one empty slot |
| verdict | output | 2 | 00 go, 01 wait, 10 insert no-op |
| strobe_err | output | 1 | Commit and no-op strobes asserted together |

## Verification
A directed walk fills one group slot by slot with cracked, condition-register, no-op and branch steps. At each step it probes the same candidates, so each slot boundary is pinned: two used versus three for the cracked limit, four for the last slot. A second walk tells the count-register no-op apart from a plain wait by adding first-only to an otherwise identical branch. It also shows that pseudo commits and clashing strobes leave the state intact. Random mixes of unit codes, flags and strobes then drive the slot counter through cracked overshoot, early close and group end in orders the directed walk does not reach.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  typedef enum logic [2:0] {
    U_PSEUDO = 3'd0,
    U_FIX    = 3'd1,
    U_LSU    = 3'd2,
    U_FPU    = 3'd3,
    U_VALU   = 3'd4,
    U_VPERM  = 3'd5,
    U_CRU    = 3'd6,
    U_BRU    = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    V_GO   = 2'b00,
    V_WAIT = 2'b01,
    V_NOOP = 2'b10
  } verdict_e;

  typedef struct packed {
    unit_e unit;
    logic  first_only;
    logic  single;
    logic  cracked;
    logic  sets_cnt;
    logic  br_cnt;
    logic  ld_overlap;
  } cand_t;

  // Units that may fill any slot except the last one.
  function automatic logic is_plain_unit(input unit_e u);
    return (u == U_FIX) || (u == U_LSU) || (u == U_FPU) ||
           (u == U_VALU) || (u == U_VPERM);
  endfunction

endpackage

// File: rtl/dgs_slot_rules.sv
module dgs_slot_rules
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int CW          = 3
) (
  input  logic [CW-1:0] used,
  input  cand_t         cand,
  output logic          first_blk,
  output logic          crack_blk,
  output logic          unit_blk,
  output logic          slot_blk
);
  localparam logic [CW-1:0] LAST_SLOT  = CW'(GROUP_SLOTS - 1);
  localparam logic [CW-1:0] CRACK_ROOM = CW'(GROUP_SLOTS - 3);
  localparam logic [CW-1:0] CR_LIMIT   = CW'(CR_SLOTS);

  // Position rule per unit class.
  function automatic logic unit_refused(input unit_e u, input logic [CW-1:0] n);
    if (is_plain_unit(u)) return n == LAST_SLOT;
    if (u == U_CRU)       return n >= CR_LIMIT;
    return 1'b0;
  endfunction

  logic real_op;

  always_comb begin
    real_op   = (cand.unit != U_PSEUDO);
    first_blk = real_op && (used != '0) && (cand.first_only || cand.single);
    crack_blk = real_op && cand.cracked && (used > CRACK_ROOM);
    unit_blk  = real_op && unit_refused(cand.unit, used);
    slot_blk  = first_blk || crack_blk || unit_blk;
  end

endmodule

// File: rtl/dgs_flush_rules.sv
module dgs_flush_rules
  import dgs_pkg::*;
(
  input  cand_t cand,
  input  logic  cnt_set,
  output logic  cnt_hit,
  output logic  noop_req
);
  always_comb begin
    cnt_hit  = (cand.unit != U_PSEUDO) && cnt_set && cand.br_cnt;
    noop_req = cnt_hit || ((cand.unit != U_PSEUDO) && cand.ld_overlap);
  end
endmodule

// File: rtl/dgs_group_state.sv
module dgs_group_state #(
  parameter int GROUP_SLOTS = 5,
  parameter int CW          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_commit,
  input  logic          take_noop,
  input  logic          closes,
  input  logic          cracked,
  input  logic          sets_cnt,
  output logic [CW-1:0] used,
  output logic          cnt_set,
  output logic          grp_end
);
  localparam logic [CW:0] FULL = (CW+1)'(GROUP_SLOTS);
  localparam logic [CW:0] LAST = (CW+1)'(GROUP_SLOTS - 1);

  // Fill level after a commit: early close jumps to the last slot first.
  function automatic logic [CW:0] fill_after(input logic [CW-1:0] cur,
                                             input logic close_now,
                                             input logic two);
    logic [CW:0] base;
    base = close_now ? LAST : {1'b0, cur};
    return base + (CW+1)'(1) + (CW+1)'(two);
  endfunction

  logic [CW:0] nxt;
  logic        moving;

  always_comb begin
    moving = take_commit || take_noop;
    if (take_commit)    nxt = fill_after(used, closes, cracked);
    else if (take_noop) nxt = {1'b0, used} + (CW+1)'(1);
    else                nxt = {1'b0, used};
    grp_end = moving && (nxt >= FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used    <= '0;
      cnt_set <= 1'b0;
    end else if (grp_end) begin
      used    <= '0;
      cnt_set <= 1'b0;
    end else begin
      if (moving) used <= nxt[CW-1:0];
      if (take_commit && sets_cnt) cnt_set <= 1'b1;
    end
  end

endmodule

// File: rtl/dgroup_slot_guard.sv
module dgroup_slot_guard
  import dgs_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cand_unit,
  input  logic       cand_first,
  input  logic       cand_single,
  input  logic       cand_cracked,
  input  logic       cand_sets_cnt,
  input  logic       cand_br_cnt,
  input  logic       cand_ld_overlap,
  input  logic       commit,
  input  logic       noop_adv,
  output logic [1:0] verdict,
  output logic       strobe_err
);
  localparam int CW = $clog2(GROUP_SLOTS + 1);

  cand_t         cand;
  logic [CW-1:0] used_q;
  logic          cnt_set_q;
  logic          grp_end;
  logic          first_blk, crack_blk, unit_blk, slot_blk;
  logic          cnt_hit, noop_req;
  logic          take_commit, take_noop, closes, is_pseudo;
  verdict_e      verdict_w;

  always_comb begin
    cand.unit       = unit_e'(cand_unit);
    cand.first_only = cand_first;
    cand.single     = cand_single;
    cand.cracked    = cand_cracked;
    cand.sets_cnt   = cand_sets_cnt;
    cand.br_cnt     = cand_br_cnt;
    cand.ld_overlap = cand_ld_overlap;
  end

  assign is_pseudo   = (cand.unit == U_PSEUDO);
  assign strobe_err  = commit && noop_adv;
  assign take_commit = commit && !noop_adv && !is_pseudo;
  assign take_noop   = noop_adv && !commit;
  assign closes      = (cand.unit == U_BRU) || cand.single;

  dgs_slot_rules #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .CR_SLOTS   (CR_SLOTS),
    .CW         (CW)
  ) u_slot (
    .used     (used_q),
    .cand     (cand),
    .first_blk(first_blk),
    .crack_blk(crack_blk),
    .unit_blk (unit_blk),
    .slot_blk (slot_blk)
  );

  dgs_flush_rules u_flush (
    .cand    (cand),
    .cnt_set (cnt_set_q),
    .cnt_hit (cnt_hit),
    .noop_req(noop_req)
  );

  dgs_group_state #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .CW         (CW)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .take_commit(take_commit),
    .take_noop  (take_noop),
    .closes     (closes),
    .cracked    (cand.cracked),
    .sets_cnt   (cand.sets_cnt),
    .used       (used_q),
    .cnt_set    (cnt_set_q),
    .grp_end    (grp_end)
  );

  // Priority: slot rules, then no-op requests.
  always_comb begin
    if (is_pseudo)     verdict_w = V_GO;
    else if (slot_blk) verdict_w = V_WAIT;
    else if (noop_req) verdict_w = V_NOOP;
    else               verdict_w = V_GO;
  end

  assign verdict = verdict_w;

endmodule

// File: rtl/dgs_guard_checker.sv
module dgs_guard_checker #(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int CW          = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cand_unit,
  input logic          cand_first,
  input logic          cand_single,
  input logic          cand_cracked,
  input logic          cand_br_cnt,
  input logic          cand_ld_overlap,
  input logic          commit,
  input logic          noop_adv,
  input logic [1:0]    verdict,
  input logic          strobe_err,
  input logic [CW-1:0] used,
  input logic          cnt_set,
  input logic          grp_end,
  input logic          slot_blk,
  input logic          take_commit,
  input logic          take_noop,
  input logic          closes
);
  localparam logic [CW-1:0] LAST_SLOT  = CW'(GROUP_SLOTS - 1);
  localparam logic [CW-1:0] CRACK_ROOM = CW'(GROUP_SLOTS - 3);
  localparam logic [CW-1:0] CR_LIMIT   = CW'(CR_SLOTS);

  logic real_op, plain_op;
  assign real_op  = (cand_unit != 3'd0);
  assign plain_op = (cand_unit >= 3'd1) && (cand_unit <= 3'd5);

  p_first_r2: assert property (@(posedge clk) disable iff (rst)
    (real_op && (cand_first || cand_single) && used != '0) |-> verdict == 2'b01);

  p_crack_refuse_r3: assert property (@(posedge clk) disable iff (rst)
    (real_op && cand_cracked && used > CRACK_ROOM) |-> verdict == 2'b01);

  p_crack_two_r3: assert property (@(posedge clk) disable iff (rst)
    (take_commit && cand_cracked && !closes && used <= CRACK_ROOM)
    |=> used == $past(used) + CW'(2));

  p_last_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (plain_op && used == LAST_SLOT) |-> verdict == 2'b01);

  p_cru_r5: assert property (@(posedge clk) disable iff (rst)
    (cand_unit == 3'd6 && used >= CR_LIMIT) |-> verdict == 2'b01);

  p_close_r6: assert property (@(posedge clk) disable iff (rst)
    (take_commit && closes) |=> used == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    used < CW'(GROUP_SLOTS));

  p_end_clear_r7: assert property (@(posedge clk) disable iff (rst)
    grp_end |=> (used == '0 && !cnt_set));

  p_cnt_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (real_op && cnt_set && cand_br_cnt && !slot_blk) |-> verdict == 2'b10);

  p_noop_one_r9: assert property (@(posedge clk) disable iff (rst)
    (take_noop && used < LAST_SLOT) |=> used == $past(used) + CW'(1));

  p_pseudo_go_r10: assert property (@(posedge clk) disable iff (rst)
    !real_op |-> verdict == 2'b00);

  p_pseudo_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (commit && !noop_adv && !real_op) |=> ($stable(used) && $stable(cnt_set)));

  p_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    (real_op && cand_ld_overlap && !slot_blk) |-> verdict == 2'b10);

  p_clash_r12: assert property (@(posedge clk) disable iff (rst)
    (commit && noop_adv) |=> ($stable(used) && $stable(cnt_set)));

  p_clash_flag_r12: assert property (@(posedge clk) disable iff (rst)
    (commit && noop_adv) |-> strobe_err);

endmodule

bind dgroup_slot_guard dgs_guard_checker #(
  .GROUP_SLOTS(GROUP_SLOTS),
  .CR_SLOTS   (CR_SLOTS),
  .CW         (CW)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cand_unit      (cand_unit),
  .cand_first     (cand_first),
  .cand_single    (cand_single),
  .cand_cracked   (cand_cracked),
  .cand_br_cnt    (cand_br_cnt),
  .cand_ld_overlap(cand_ld_overlap),
  .commit         (commit),
  .noop_adv       (noop_adv),
  .verdict        (verdict),
  .strobe_err     (strobe_err),
  .used           (used_q),
  .cnt_set        (cnt_set_q),
  .grp_end        (grp_end),
  .slot_blk       (slot_blk),
  .take_commit    (take_commit),
  .take_noop      (take_noop),
  .closes         (closes)
);

// File: tb/tb_dgroup_slot_guard.sv
module tb_dgroup_slot_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cand_unit = '0;
  logic       cand_first = 0, cand_single = 0, cand_cracked = 0;
  logic       cand_sets_cnt = 0, cand_br_cnt = 0, cand_ld_overlap = 0;
  logic       commit = 0, noop_adv = 0;
  logic [1:0] verdict;
  logic       strobe_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int m_used = 0;
  bit m_cnt  = 0;

  always #10 clk = ~clk;

  dgroup_slot_guard dut (
    .clk(clk), .rst(rst),
    .cand_unit(cand_unit), .cand_first(cand_first), .cand_single(cand_single),
    .cand_cracked(cand_cracked), .cand_sets_cnt(cand_sets_cnt),
    .cand_br_cnt(cand_br_cnt), .cand_ld_overlap(cand_ld_overlap),
    .commit(commit), .noop_adv(noop_adv),
    .verdict(verdict), .strobe_err(strobe_err)
  );

  function automatic logic [1:0] exp_verdict(input int u, input bit fo, input bit sg,
                                             input bit cr, input bit bc, input bit lo);
    if (u == 0) return 2'b00;
    if ((fo || sg) && m_used > 0) return 2'b01;
    if (cr && m_used >= 3) return 2'b01;
    if (u >= 1 && u <= 5 && m_used == 4) return 2'b01;
    if (u == 6 && m_used >= 2) return 2'b01;
    if (bc && m_cnt) return 2'b10;
    if (lo) return 2'b10;
    return 2'b00;
  endfunction

  task automatic model_step(input int u, input bit sg, input bit cr, input bit sc,
                            input bit cm, input bit np);
    int n;
    if (cm && np) return;
    if (cm && u != 0) begin
      n = ((u == 7) || sg) ? 4 : m_used;
      n = n + 1 + (cr ? 1 : 0);
      if (sc) m_cnt = 1;
      if (n >= 5) begin m_used = 0; m_cnt = 0; end
      else m_used = n;
    end else if (np) begin
      n = m_used + 1;
      if (n >= 5) begin m_used = 0; m_cnt = 0; end
      else m_used = n;
    end
  endtask

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (slots=%0d)", tag, act, exp, m_used);
    end
  endtask

  task automatic drive(input int u, input bit fo, input bit sg, input bit cr,
                       input bit sc, input bit bc, input bit lo,
                       input bit cm, input bit np, input string tag);
    @(negedge clk);
    cand_unit = u[2:0]; cand_first = fo; cand_single = sg; cand_cracked = cr;
    cand_sets_cnt = sc; cand_br_cnt = bc; cand_ld_overlap = lo;
    commit = cm; noop_adv = np;
    #1;
    check(verdict, exp_verdict(u, fo, sg, cr, bc, lo), tag);
    check({1'b0, strobe_err}, {1'b0, cm && np}, "R12 clash flag");
    model_step(u, sg, cr, sc, cm, np);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty group after reset
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1 first-only on empty group");
    drive(6, 0, 0, 0, 0, 0, 0, 1, 0, "R1 CR unit on empty group");
    // one slot used
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0, "R2 single refused at slot 1");
    drive(1, 0, 0, 1, 0, 0, 0, 1, 0, "R3 cracked allowed at slot 1");
    // three used
    drive(6, 0, 0, 0, 0, 0, 0, 0, 0, "R5 CR refused at slot 3");
    drive(2, 0, 0, 1, 0, 0, 0, 0, 0, "R3 cracked refused at slot 3");
    drive(3, 0, 0, 0, 0, 0, 0, 0, 0, "R3 plain ok at slot 3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 noop strobe");
    // four used
    drive(3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 float refused in last slot");
    drive(5, 0, 0, 0, 0, 0, 0, 0, 0, "R4 vperm refused in last slot");
    drive(7, 0, 0, 0, 0, 0, 0, 1, 0, "R4 branch ok in last slot");
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0, "R6 group restarted after branch");
    // early close by branch from slot 1
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0, "R6 plain commit");
    drive(7, 0, 0, 0, 0, 0, 0, 1, 0, "R6 branch commit closes");
    drive(6, 1, 0, 0, 0, 0, 0, 0, 0, "R6 empty after early close");
    // count register rule
    drive(1, 0, 0, 0, 1, 0, 0, 1, 0, "R8 count write");
    drive(7, 0, 0, 0, 0, 1, 0, 0, 0, "R8 indirect branch needs noop");
    drive(7, 1, 0, 0, 0, 1, 0, 0, 0, "R8 slot rule wins over noop");
    drive(2, 0, 0, 0, 0, 0, 1, 0, 0, "R11 load overlap needs noop");
    drive(6, 0, 0, 0, 0, 0, 1, 0, 0, "R11 overlap on CR unit");
    // pseudo commit changes nothing
    drive(0, 1, 1, 1, 1, 1, 1, 1, 0, "R10 pseudo always go");
    drive(6, 0, 0, 0, 0, 1, 0, 0, 0, "R10 state kept after pseudo");
    // strobe clash
    drive(2, 0, 0, 0, 0, 0, 0, 1, 1, "R12 clash cycle");
    drive(6, 0, 0, 0, 0, 0, 0, 0, 0, "R12 slots unchanged by clash");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 noop to slot 2");
    drive(6, 0, 0, 0, 0, 0, 0, 0, 0, "R9 CR refused at slot 2");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 noop to slot 3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 noop to slot 4");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 noop fills group");
    drive(7, 0, 0, 0, 0, 1, 0, 0, 0, "R7 count flag cleared at end");
    drive(6, 1, 0, 0, 0, 0, 0, 0, 0, "R7 slots zero after end");
    // cracked overshoot on a single
    drive(1, 0, 1, 1, 0, 0, 0, 1, 0, "R6 cracked single closes");
    drive(6, 1, 0, 0, 0, 0, 0, 0, 0, "R6 empty after single");

    for (int i = 0; i < 4000; i++) begin
      int u;
      bit fo, sg, cr, sc, bc, lo, cm, np;
      u  = int'($urandom % 8);
      fo = ($urandom % 8) == 0;
      sg = ($urandom % 10) == 0;
      cr = ($urandom % 5) == 0;
      sc = ($urandom % 6) == 0;
      bc = ($urandom % 4) == 0;
      lo = ($urandom % 7) == 0;
      cm = ($urandom % 2) == 0;
      np = ($urandom % 5) == 0;
      drive(u, fo, sg, cr, sc, bc, lo, cm, np,
            "random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    @(negedge clk);
    commit = 0; noop_adv = 0;
    finish_run();
  end

endmodule